// File: doc/BRIEF.md
# Multi-Stage Sequential Trigger

This block watches a word of sampled logic channels and raises a one-cycle capture trigger once a programmed chain of conditions has been met in order. Each of its stages holds a channel mask, a compare value, an edge-select word and a configuration word. The configuration word gives the stage an arming level and, optionally, a start flag. A counter holds the current arming level. Only stages whose level equals it take part in matching. A matching stage without the start flag moves the counter up by one. A matching stage with the start flag fires the trigger.

Per channel, the mask says whether the bit takes part, the value says which polarity is wanted, and the edge bit says whether that polarity must be reached by a transition from the previous accepted sample. Software loads the stages through a small write port and then issues a run strobe. The strobe clears the level counter and the stored previous sample, and it arms the block. After the trigger fires, the block stays disarmed until the next run strobe. A stage that takes no part in the chain is parked with mask and value zero, edge zero and level 3. If no condition is wanted, stage 0 is given a zero mask and the start flag, and the first sample after run fires.

Top module: `seq_trigger`

## Requirements
- R1: After reset `trig` is low and the block is disarmed, so samples taken before the first `run` never produce a trigger.
- R2: A stage compares only the channels whose mask bit is 1 against its value word; channels with mask bit 0 have no effect on whether it matches.
- R3: A channel whose edge bit is 1 matches only when the previous accepted sample differs from the value bit and the current sample equals it: value 1 means a rising edge, value 0 means a falling edge.
- R4: `run` clears the stored previous sample to all zeros, so the first sample after `run` counts as rising on every channel that is 1 and never as falling.
- R5: When an armed block accepts a sample (`smp_valid` high) on which a start-flagged stage matches and that stage's level equals the current level, `trig` is high for exactly the one cycle after that clock edge.
- R6: A matching stage without the start flag whose level equals the current level raises the current level by one. It saturates at the highest level. Stages at other levels are ignored.
- R7: After firing, the block is disarmed, and no further trigger occurs until the next `run`.
- R8: `run` sets the current level to 0 and arms the block, whatever the earlier progress.
- R9: A stage with an all-zero mask matches every accepted sample. A start-flagged stage 0 at level 0 with a zero mask therefore fires on the first sample after `run`.
- R10: In a cycle with `smp_valid` low, the level does not change, no trigger is raised, and the previous sample is not updated.
- R11: A write with `cfg_we` high loads the stage `cfg_sel` and the word selected by `cfg_kind`: 0 mask, 1 value, 2 config, 3 edge. In the config word, bits [17:16] hold the level and bit 27 holds the start flag. A write takes effect for the sample of the following cycle.
- R12: When a start-flagged stage and a non-start stage both match at the current level on the same sample, the trigger fires and the level does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Stage register write strobe |
| cfg_sel | input | 2 | Stage index of the write |
| cfg_kind | input | 2 | Word selected: 0 mask, 1 value, 2 config, 3 edge |
| cfg_wdata | input | 32 | Write data |
| run | input | 1 | Arm strobe: clears level and previous sample |
| smp_valid | input | 1 | Sample enable |
| smp_data | input | 32 | Sampled channel word |
| trig | output | 1 | Capture trigger pulse |

## Verification
`trig` is due exactly one cycle after the clock edge that accepts the deciding sample. A register write or a `run` strobe affects the sample driven in the following cycle. The bench drives one stimulus per cycle just after a rising edge. For every cycle it queues the expected trigger value, tagged with the cycle in which that value must appear. A monitor samples `trig` a few nanoseconds after each rising edge and compares only the entries whose due cycle has come. Zero-trigger cycles, such as disarmed samples, idle cycles and level advances, are therefore checked as strictly as the firing cycle.

// File: rtl/seq_trigger_pkg.sv
package seq_trigger_pkg;
  typedef enum logic [1:0] {
    KIND_MASK   = 2'd0,
    KIND_VALUE  = 2'd1,
    KIND_CONFIG = 2'd2,
    KIND_EDGE   = 2'd3
  } cfg_kind_e;

  // config word layout (level field sits in byte 2, start flag in byte 3)
  localparam int CFG_LVL_LSB   = 16;
  localparam int CFG_START_BIT = 27;
endpackage

// File: rtl/seq_trigger_stage.sv
module seq_trigger_stage
  import seq_trigger_pkg::*;
#(
  parameter int CH_W  = 32,
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_kind,
  input  logic [CH_W-1:0]  wr_data,
  input  logic [CH_W-1:0]  cur_smp,
  input  logic [CH_W-1:0]  prev_smp,
  output logic             hit,
  output logic [LVL_W-1:0] lvl,
  output logic             is_start
);
  logic [CH_W-1:0]  mask_q, val_q, edge_q;
  logic [LVL_W-1:0] lvl_q;
  logic             start_q;
  cfg_kind_e        kind;

  // per-channel acceptance: level match, plus a transition when edge-selected
  function automatic logic stage_match(input logic [CH_W-1:0] m, input logic [CH_W-1:0] v,
                                       input logic [CH_W-1:0] e, input logic [CH_W-1:0] c,
                                       input logic [CH_W-1:0] p);
    logic [CH_W-1:0] ok;
    ok = ~(c ^ v) & (~e | (p ^ v));
    return &(ok | ~m);
  endfunction

  assign kind = cfg_kind_e'(wr_kind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      val_q   <= '0;
      edge_q  <= '0;
      lvl_q   <= '0;
      start_q <= 1'b0;
    end else if (wr_en) begin
      case (kind)
        KIND_MASK:   mask_q <= wr_data;
        KIND_VALUE:  val_q  <= wr_data;
        KIND_EDGE:   edge_q <= wr_data;
        KIND_CONFIG: begin
          lvl_q   <= wr_data[CFG_LVL_LSB +: LVL_W];
          start_q <= wr_data[CFG_START_BIT];
        end
        default: ;
      endcase
    end
  end

  assign hit      = stage_match(mask_q, val_q, edge_q, cur_smp, prev_smp);
  assign lvl      = lvl_q;
  assign is_start = start_q;

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == 2'd0) |=> mask_q == $past(wr_data)); // R11
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == 2'd2) |=> start_q == $past(wr_data[CFG_START_BIT])); // R11
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(lvl_q) && $stable(start_q)); // R11
endmodule

// File: rtl/seq_trigger_ctrl.sv
module seq_trigger_ctrl #(
  parameter int N_STG = 4,
  parameter int LVL_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        run,
  input  logic                        smp_valid,
  input  logic [N_STG-1:0]            hit,
  input  logic [N_STG-1:0]            is_start,
  input  logic [N_STG-1:0][LVL_W-1:0] lvl,
  output logic                        trig,
  output logic                        armed
);
  localparam logic [LVL_W-1:0] LVL_TOP = '1;

  logic [LVL_W-1:0] level_q;
  logic             armed_q, trig_q;
  logic [N_STG-1:0] go_fire, go_adv;
  logic             take, fire, advance;

  for (genvar i = 0; i < N_STG; i++) begin : g_elig
    assign go_fire[i] = hit[i] && (lvl[i] == level_q) &&  is_start[i];
    assign go_adv[i]  = hit[i] && (lvl[i] == level_q) && !is_start[i];
  end

  assign take    = armed_q && smp_valid && !run;
  assign fire    = take && (|go_fire);
  assign advance = take && !fire && (|go_adv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= fire;
      if (run) begin
        level_q <= '0;
        armed_q <= 1'b1;
      end else begin
        if (fire) armed_q <= 1'b0;
        if (advance && level_q != LVL_TOP) level_q <= level_q + 1'b1;
      end
    end
  end

  assign trig  = trig_q;
  assign armed = armed_q;

  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |=> !trig_q); // R5
  AST_TRIG_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> !armed_q); // R7
  AST_RUN_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (level_q == '0) && armed_q && !trig_q); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !smp_valid) |=> $stable(level_q) && !trig_q); // R10
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (level_q == $past(level_q)) || (level_q == $past(level_q) + 1'b1)); // R6
  AST_FIRE_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !run) |=> $stable(level_q)); // R12
  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !run) |=> !trig_q); // R1
endmodule

// File: rtl/seq_trigger.sv
module seq_trigger #(
  parameter int CH_W  = 32,
  parameter int N_STG = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(N_STG)-1:0] cfg_sel,
  input  logic [1:0]               cfg_kind,
  input  logic [CH_W-1:0]          cfg_wdata,
  input  logic                     run,
  input  logic                     smp_valid,
  input  logic [CH_W-1:0]          smp_data,
  output logic                     trig
);
  localparam int SEL_W = $clog2(N_STG);
  localparam int LVL_W = SEL_W;

  logic [CH_W-1:0]              prev_q;
  logic [N_STG-1:0]             hit, is_start;
  logic [N_STG-1:0][LVL_W-1:0]  lvl;
  logic                         armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         prev_q <= '0;
    else if (run)       prev_q <= '0;
    else if (smp_valid) prev_q <= smp_data;
  end

  for (genvar s = 0; s < N_STG; s++) begin : g_stage
    seq_trigger_stage #(.CH_W(CH_W), .LVL_W(LVL_W)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we && (cfg_sel == SEL_W'(s))),
      .wr_kind  (cfg_kind),
      .wr_data  (cfg_wdata),
      .cur_smp  (smp_data),
      .prev_smp (prev_q),
      .hit      (hit[s]),
      .lvl      (lvl[s]),
      .is_start (is_start[s])
    );
  end

  seq_trigger_ctrl #(.N_STG(N_STG), .LVL_W(LVL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .smp_valid (smp_valid),
    .hit       (hit),
    .is_start  (is_start),
    .lvl       (lvl),
    .trig      (trig),
    .armed     (armed)
  );

  AST_PREV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> prev_q == '0); // R4
  AST_PREV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !smp_valid) |=> $stable(prev_q)); // R10
endmodule

// File: tb/seq_trigger_tb.sv
module seq_trigger_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [1:0]  cfg_kind = '0;
  logic [31:0] cfg_wdata = '0;
  logic        run = 1'b0;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_data = '0;
  logic        trig;

  seq_trigger u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_kind(cfg_kind), .cfg_wdata(cfg_wdata), .run(run),
    .smp_valid(smp_valid), .smp_data(smp_data), .trig(trig)
  );

  always #5 clk = ~clk;

  typedef struct {
    int    due;
    bit    exp;
    string req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares trig against entries whose due cycle has arrived
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (trig !== e.exp) begin
          n_bad++;
          $display("FAIL %s: trig=%0b expected %0b at cycle %0d", e.req, trig, e.exp, cyc);
        end
      end
    end
  end

  function automatic logic [31:0] cfg_word(input int level, input bit start);
    return (32'(level) << 16) | (start ? 32'h0800_0000 : 32'h0);
  endfunction

  task automatic drive(input bit we, input int sel, input int kind, input logic [31:0] wd,
                       input bit r, input bit v, input logic [31:0] d,
                       input bit exp, input string req);
    exp_t e;
    @(posedge clk);
    #1;
    cfg_we = we; cfg_sel = 2'(sel); cfg_kind = 2'(kind); cfg_wdata = wd;
    run = r; smp_valid = v; smp_data = d;
    e.due = cyc + 1; e.exp = exp; e.req = req;
    q.push_back(e);
  endtask

  task automatic wr(input int sel, input int kind, input logic [31:0] wd);
    drive(1'b1, sel, kind, wd, 1'b0, 1'b0, '0, 1'b0, "R11");
  endtask

  task automatic arm();
    drive(1'b0, 0, 0, '0, 1'b1, 1'b0, '0, 1'b0, "R8");
  endtask

  task automatic smp(input bit v, input logic [31:0] d, input bit exp, input string req);
    drive(1'b0, 0, 0, '0, 1'b0, v, d, exp, req);
  endtask

  task automatic park(input int s);
    wr(s, 0, '0); wr(s, 1, '0); wr(s, 3, '0); wr(s, 2, cfg_word(3, 0));
  endtask

  task automatic setup(input int s, input logic [31:0] m, input logic [31:0] v,
                       input logic [31:0] e, input int level, input bit start);
    wr(s, 0, m); wr(s, 1, v); wr(s, 3, e); wr(s, 2, cfg_word(level, start));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (trig !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: trig=%0b expected 0 in reset", trig);
    end
    rst_n = 1'b1;

    // R1: default registers match everything, but block is not armed
    smp(1'b1, 32'hFFFF_FFFF, 1'b0, "R1");
    smp(1'b1, 32'h0, 1'b0, "R1");

    // R9/R5/R7: immediate capture with zero-mask start stage 0
    for (int s = 1; s < 4; s++) park(s);
    setup(0, '0, '0, '0, 0, 1'b1);
    arm();
    smp(1'b1, 32'hDEAD_BEEF, 1'b1, "R9");
    smp(1'b1, 32'hDEAD_BEEF, 1'b0, "R7");
    smp(1'b1, 32'h0, 1'b0, "R7");

    // R2/R10: masked level compare on low byte
    setup(0, 32'h0000_00FF, 32'h0000_005A, '0, 0, 1'b1);
    arm();
    smp(1'b0, 32'h0000_005A, 1'b0, "R10");
    smp(1'b1, 32'h1234_5600, 1'b0, "R2");
    smp(1'b1, 32'hFFFF_FF5A, 1'b1, "R2");

    // R6: two-level chain, stage at a higher level ignored until reached
    setup(0, 32'hF, 32'h1, '0, 0, 1'b0);
    setup(1, 32'hF, 32'h2, '0, 1, 1'b1);
    arm();
    smp(1'b1, 32'h2, 1'b0, "R6");
    smp(1'b1, 32'h1, 1'b0, "R6");
    smp(1'b0, 32'h2, 1'b0, "R10");
    smp(1'b1, 32'h2, 1'b1, "R6");

    // R8: rerun drops progress back to level 0
    arm();
    smp(1'b1, 32'h1, 1'b0, "R6");
    arm();
    smp(1'b1, 32'h2, 1'b0, "R8");
    smp(1'b1, 32'h1, 1'b0, "R8");
    smp(1'b1, 32'h2, 1'b1, "R8");

    // R12: fire and advance candidates at the same level
    setup(1, 32'hF0, 32'h10, '0, 0, 1'b1);
    arm();
    smp(1'b1, 32'h11, 1'b1, "R12");
    // level must still be 0: a stage-1 write back to level 1 start, stage 0 advance
    setup(1, 32'hF, 32'h2, '0, 1, 1'b1);
    arm();
    smp(1'b1, 32'h2, 1'b0, "R12");
    park(1);

    // R3/R4: falling edge on bit 0
    setup(0, 32'h1, 32'h0, 32'h1, 0, 1'b1);
    arm();
    smp(1'b1, 32'h0, 1'b0, "R4");
    smp(1'b1, 32'h1, 1'b0, "R3");
    smp(1'b1, 32'h1, 1'b0, "R3");
    smp(1'b1, 32'h0, 1'b1, "R3");

    // R4: rising edge counts on first sample after run
    setup(0, 32'h1, 32'h1, 32'h1, 0, 1'b1);
    arm();
    smp(1'b1, 32'h1, 1'b1, "R4");
    arm();
    smp(1'b1, 32'h1, 1'b1, "R4");

    // R10/R3: invalid cycle does not update previous sample
    arm();
    smp(1'b1, 32'h0, 1'b0, "R3");
    smp(1'b0, 32'h1, 1'b0, "R10");
    smp(1'b1, 32'h1, 1'b1, "R10");
    smp(1'b1, 32'h0, 1'b0, "R7");

    smp(1'b0, 32'h0, 1'b0, "R7");
    repeat (3) @(posedge clk);
    #5;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule